// File: doc/BRIEF.md
# Idle standby and wake controller

This block puts a small processor subsystem into a low-power idle state and brings it back out. Software first selects idle through a mode bit and then sets a standby bit. The controller then drops the clock enables for the CPU and for the peripherals that run from the internal clock. The enable for peripherals clocked from outside stays high, and the clock generator and PLL are never stopped. No stabilization wait is needed on release, so the CPU restarts two cycles after the wake source is seen.

Idle can be released by an unmasked maskable interrupt request, a non-maskable request, or any reset source. On release the block gives a one-cycle wake pulse, a flag and a request index. The flag tells the CPU to branch to the winning request's handler, or to resume at the next instruction and leave the request pending. That choice depends on the winner's priority compared with the level in service when idle was entered.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset, cpu_clk_en, per_clk_en and ext_per_clk_en are 1, and idle_state and wake_pulse are 0. The mode-select bit resets to 1 and the standby bit resets to 0.
- R2: A write of 1 to bit 0 of control register address 1, with mode-select (bit 0 of address 0) at 0, sets idle_state to 1. It also sets cpu_clk_en and per_clk_en to 0, two cycles after the write cycle.
- R3: A standby write made while mode-select is 1 is ignored, and the block stays running.
- R4: ext_per_clk_en stays 1 during idle.
- R5: A request that is set in irq_req and clear in irq_mask, with the global disable (bit 1 of address 1) at 0, releases idle whatever its priority. The enables go high two cycles after the request is first seen, together with a wake_pulse that lasts exactly one cycle.
- R6: A masked request cannot release idle. While the global disable is 1, no maskable request can release idle.
- R7: With in_service at 0, or with a winning priority strictly above isr_level, take_irq is 1. The winner is the eligible request with the largest irq_prio value. Among equal priorities the lowest index wins.
- R8: With in_service at 1 and a winning priority less than or equal to isr_level, the wake gives take_irq 0, which means resume at the next instruction.
- R9: nmi releases idle even when the global disable is 1, and gives take_irq 1 with wake_idx equal to N_IRQ.
- R10: lvd_rst or poc_rst leaves idle at the next edge and returns the registers to their defaults. Mode-select is then 1, so a later standby write does not enter idle.
- R11: The standby bit clears itself on release, so the block stays running after a wake without any new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running system clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| lvd_rst | input | 1 | Low-voltage detect reset, active high, synchronous |
| poc_rst | input | 1 | Power-on-clear reset, active high, synchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 is mode, 1 is control |
| wr_data | input | DATA_W | Write data |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_mask | input | N_IRQ | Mask bits, 1 means masked |
| irq_prio | input | N_IRQ*PRIO_W | Priority of each request, packed by index; a larger value is more urgent |
| in_service | input | 1 | A maskable interrupt is being serviced |
| isr_level | input | PRIO_W | Priority of the interrupt in service |
| nmi | input | 1 | Non-maskable request |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Enable for internally clocked peripherals |
| ext_per_clk_en | output | 1 | Enable for externally clocked peripherals |
| idle_state | output | 1 | Controller is in idle |
| wake_pulse | output | 1 | One-cycle release indication |
| take_irq | output | 1 | 1 means branch to the handler, 0 means resume at the next instruction |
| wake_idx | output | $clog2(N_IRQ+1) | Winning request index; N_IRQ stands for nmi |

## Verification
The assertions assume the decision for each release is taken from the request and priority inputs seen on the cycle idle first observes a wake source. They also assume lvd_rst and poc_rst are synchronous to clk. The stimulus changes every input at the falling edge and holds each request until the wake pulse has been checked. It writes registers only while the block is running, and it drives the in-service level before idle is entered, so no decision sees a changing input.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;
   typedef enum logic {ST_RUN = 1'b0, ST_IDLE = 1'b1} pwr_state_e;
   localparam int unsigned ADDR_MODE = 0;
   localparam int unsigned ADDR_CTRL = 1;
endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs #(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter bit          MODE_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              running,
   input  logic              release_i,
   output logic              mode_sel,
   output logic              standby,
   output logic              gdis
);
   import idle_wake_pkg::*;

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_sel <= MODE_RST;
         standby  <= 1'b0;
         gdis     <= 1'b0;
      end else if (src_rst) begin
         mode_sel <= MODE_RST;
         standby  <= 1'b0;
         gdis     <= 1'b0;
      end else begin
         if (release_i) standby <= 1'b0;
         if (wr_en && running) begin
            if (wr_addr == ADDR_W'(ADDR_MODE)) begin
               mode_sel <= wr_data[0];
            end else if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
               gdis    <= wr_data[1];
               standby <= wr_data[0] & ~mode_sel;
            end
         end
      end
   end
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
   parameter int unsigned N_IRQ    = 4,
   parameter int unsigned PRIO_W   = 3,
   parameter bit          TIE_LOW  = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_IRQ + 1)
) (
   input  logic                    gdis,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_mask,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic                    in_service,
   input  logic [PRIO_W-1:0]       isr_level,
   input  logic                    nmi,
   output logic                    wake_evt,
   output logic                    take,
   output logic [IDX_W-1:0]        idx
);
   logic [N_IRQ-1:0]  elig;
   logic              best_vld;
   logic [PRIO_W-1:0] best_prio;
   logic [IDX_W-1:0]  best_idx;
   logic [PRIO_W-1:0] cur;

   for (genvar g = 0; g < N_IRQ; g++) begin : g_elig
      assign elig[g] = irq_req[g] & ~irq_mask[g] & ~gdis;
   end

   always_comb begin
      best_vld  = 1'b0;
      best_prio = '0;
      best_idx  = '0;
      cur       = '0;
      for (int i = 0; i < N_IRQ; i++) begin
         cur = irq_prio[i*PRIO_W +: PRIO_W];
         if (elig[i] && (!best_vld || cur > best_prio ||
                         (cur == best_prio && !TIE_LOW))) begin
            best_vld  = 1'b1;
            best_prio = cur;
            best_idx  = IDX_W'(i);
         end
      end
   end

   assign wake_evt = nmi | best_vld;
   assign take     = nmi | ~in_service | (best_prio > isr_level);
   assign idx      = nmi ? IDX_W'(N_IRQ) : best_idx;
endmodule

// File: rtl/clk_gate_seq.sv
module clk_gate_seq #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_rst,
   input  logic             standby,
   input  logic             mode_sel,
   input  logic             wake_evt,
   input  logic             take_in,
   input  logic [IDX_W-1:0] idx_in,
   output logic             idle_o,
   output logic             cpu_en,
   output logic             per_en,
   output logic             pulse,
   output logic             take_q,
   output logic [IDX_W-1:0] idx_q,
   output logic             release_o
);
   import idle_wake_pkg::*;

   pwr_state_e state;
   logic       pend;

   assign idle_o    = (state == ST_IDLE);
   assign release_o = (state == ST_IDLE) && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         pend   <= 1'b0;
         pulse  <= 1'b0;
         cpu_en <= 1'b1;
         per_en <= 1'b1;
         take_q <= 1'b0;
         idx_q  <= '0;
      end else if (src_rst) begin
         state  <= ST_RUN;
         pend   <= 1'b0;
         pulse  <= 1'b0;
         cpu_en <= 1'b1;
         per_en <= 1'b1;
      end else begin
         pulse <= 1'b0;
         case (state)
            ST_RUN: begin
               if (standby && !mode_sel) begin
                  state  <= ST_IDLE;
                  cpu_en <= 1'b0;
                  per_en <= 1'b0;
               end
            end
            default: begin
               if (pend) begin
                  state  <= ST_RUN;
                  pend   <= 1'b0;
                  pulse  <= 1'b1;
                  cpu_en <= 1'b1;
                  per_en <= 1'b1;
               end else if (wake_evt) begin
                  pend   <= 1'b1;
                  take_q <= take_in;
                  idx_q  <= idx_in;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
   parameter int unsigned N_IRQ    = 4,
   parameter int unsigned PRIO_W   = 3,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter bit          TIE_LOW  = 1'b1,
   parameter bit          MODE_RST = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_IRQ + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lvd_rst,
   input  logic                    poc_rst,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_mask,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic                    in_service,
   input  logic [PRIO_W-1:0]       isr_level,
   input  logic                    nmi,
   output logic                    cpu_clk_en,
   output logic                    per_clk_en,
   output logic                    ext_per_clk_en,
   output logic                    idle_state,
   output logic                    wake_pulse,
   output logic                    take_irq,
   output logic [IDX_W-1:0]        wake_idx
);
   if (N_IRQ < 1) begin : g_bad_nirq
      $error("N_IRQ must be at least 1");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 3) begin : g_bad_bus
      $error("ADDR_W must be >= 1 and DATA_W >= 3");
   end

   logic src_rst, mode_sel, standby, gdis, release_s;
   logic wake_evt, take_c;
   logic [IDX_W-1:0] idx_c;

   assign src_rst        = lvd_rst | poc_rst;
   assign ext_per_clk_en = 1'b1;

   pwr_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_RST(MODE_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .src_rst(src_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .running(~idle_state), .release_i(release_s),
      .mode_sel(mode_sel), .standby(standby), .gdis(gdis)
   );

   wake_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .TIE_LOW(TIE_LOW)) u_arb (
      .gdis(gdis), .irq_req(irq_req), .irq_mask(irq_mask), .irq_prio(irq_prio),
      .in_service(in_service), .isr_level(isr_level), .nmi(nmi),
      .wake_evt(wake_evt), .take(take_c), .idx(idx_c)
   );

   clk_gate_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .src_rst(src_rst),
      .standby(standby), .mode_sel(mode_sel),
      .wake_evt(wake_evt), .take_in(take_c), .idx_in(idx_c),
      .idle_o(idle_state), .cpu_en(cpu_clk_en), .per_en(per_clk_en),
      .pulse(wake_pulse), .take_q(take_irq), .idx_q(wake_idx),
      .release_o(release_s)
   );
endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk #(
   parameter int unsigned N_IRQ = 4,
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lvd_rst,
   input logic             poc_rst,
   input logic             nmi,
   input logic             in_service,
   input logic             idle_state,
   input logic             cpu_clk_en,
   input logic             ext_per_clk_en,
   input logic             wake_pulse,
   input logic             take_irq,
   input logic [IDX_W-1:0] wake_idx
);
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_pulse_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(idle_state) && cpu_clk_en);

   assert_ext_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idle_state |-> ext_per_clk_en);

   assert_src_reset_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvd_rst || poc_rst) |=> !idle_state && !wake_pulse);

   assert_nmi_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && $past(nmi, 2)) |-> (take_irq && wake_idx == IDX_W'(N_IRQ)));

   assert_idle_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !$past(in_service, 2)) |-> take_irq);

   assert_exit_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(idle_state) && !$past(lvd_rst) && !$past(poc_rst)) |-> wake_pulse);
endmodule

bind idle_wake_ctrl idle_wake_chk #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lvd_rst(lvd_rst), .poc_rst(poc_rst),
   .nmi(nmi), .in_service(in_service), .idle_state(idle_state),
   .cpu_clk_en(cpu_clk_en), .ext_per_clk_en(ext_per_clk_en),
   .wake_pulse(wake_pulse), .take_irq(take_irq), .wake_idx(wake_idx)
);

// File: tb/idle_wake_ctrl_test.sv
module idle_wake_ctrl_test;
   localparam int N  = 4;
   localparam int PW = 3;
   localparam int IW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0, lvd_rst = 1'b0, poc_rst = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [N-1:0] irq_req = '0, irq_mask = '0;
   logic [N*PW-1:0] irq_prio = '0;
   logic in_service = 1'b0;
   logic [PW-1:0] isr_level = '0;
   logic nmi = 1'b0;
   logic cpu_clk_en, per_clk_en, ext_per_clk_en, idle_state, wake_pulse, take_irq;
   logic [IW-1:0] wake_idx;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   idle_wake_ctrl uut (
      .clk(clk), .rst_n(rst_n), .lvd_rst(lvd_rst), .poc_rst(poc_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_req(irq_req), .irq_mask(irq_mask), .irq_prio(irq_prio),
      .in_service(in_service), .isr_level(isr_level), .nmi(nmi),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .ext_per_clk_en(ext_per_clk_en),
      .idle_state(idle_state), .wake_pulse(wake_pulse), .take_irq(take_irq),
      .wake_idx(wake_idx)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_prio(input int i, input logic [PW-1:0] p);
      irq_prio[i*PW +: PW] = p;
   endtask

   task automatic enter_idle(input bit gd, input string tag);
      wr(2'd0, 8'h00);
      wr(2'd1, {6'd0, gd, 1'b1});
      cyc(1);
      chk({tag, " idle_state"}, {31'd0, idle_state}, 1);
      chk({tag, " cpu_clk_en"}, {31'd0, cpu_clk_en}, 0);
      chk({tag, " per_clk_en"}, {31'd0, per_clk_en}, 0);
   endtask

   task automatic expect_wake(input string tag, input bit tk, input int idx);
      cyc(1);
      chk({tag, " still gated"}, {31'd0, cpu_clk_en}, 0);
      chk({tag, " no early pulse"}, {31'd0, wake_pulse}, 0);
      cyc(1);
      chk({tag, " pulse"}, {31'd0, wake_pulse}, 1);
      chk({tag, " cpu_clk_en"}, {31'd0, cpu_clk_en}, 1);
      chk({tag, " per_clk_en"}, {31'd0, per_clk_en}, 1);
      chk({tag, " take_irq"}, {31'd0, take_irq}, {31'd0, tk});
      chk({tag, " wake_idx"}, 32'(wake_idx), 32'(idx));
      irq_req = '0; nmi = 1'b0;
      cyc(1);
      chk({tag, " pulse one cycle"}, {31'd0, wake_pulse}, 0);
   endtask

   task automatic t_reset;
      chk("R1 cpu_clk_en", {31'd0, cpu_clk_en}, 1);
      chk("R1 per_clk_en", {31'd0, per_clk_en}, 1);
      chk("R1 ext_per_clk_en", {31'd0, ext_per_clk_en}, 1);
      chk("R1 idle_state", {31'd0, idle_state}, 0);
      chk("R1 wake_pulse", {31'd0, wake_pulse}, 0);
   endtask

   task automatic t_mode_ignore;
      wr(2'd1, 8'h01);
      cyc(6);
      chk("R3 mode 1 standby ignored", {31'd0, idle_state}, 0);
      chk("R3 cpu still enabled", {31'd0, cpu_clk_en}, 1);
   endtask

   task automatic t_basic_wake;
      set_prio(1, 3'd2);
      enter_idle(1'b0, "R2 entry");
      chk("R4 ext enable in idle", {31'd0, ext_per_clk_en}, 1);
      irq_req[1] = 1'b1;
      expect_wake("R5 basic wake", 1'b1, 1);
      cyc(6);
      chk("R11 standby self-cleared", {31'd0, idle_state}, 0);
   endtask

   task automatic t_mask;
      irq_mask = 4'b0100;
      set_prio(2, 3'd7);
      enter_idle(1'b0, "R6 mask entry");
      irq_req[2] = 1'b1;
      cyc(5);
      chk("R6 masked request no wake", {31'd0, idle_state}, 1);
      irq_mask = '0;
      expect_wake("R6 unmask wakes", 1'b1, 2);
   endtask

   task automatic t_gdis_nmi;
      set_prio(0, 3'd4);
      enter_idle(1'b1, "R6 gdis entry");
      irq_req[0] = 1'b1;
      cyc(5);
      chk("R6 global disable blocks wake", {31'd0, idle_state}, 1);
      nmi = 1'b1;
      expect_wake("R9 nmi wake", 1'b1, N);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_priority;
      in_service = 1'b1; isr_level = 3'd4;
      set_prio(0, 3'd3); set_prio(2, 3'd5); set_prio(3, 3'd5);
      enter_idle(1'b0, "R7 prio entry");
      irq_req = 4'b1101;
      expect_wake("R7 higher priority takes, tie low idx", 1'b1, 2);
   endtask

   task automatic t_resume;
      in_service = 1'b1; isr_level = 3'd5;
      set_prio(3, 3'd5);
      enter_idle(1'b0, "R8 equal entry");
      irq_req = 4'b1000;
      expect_wake("R8 equal priority resumes", 1'b0, 3);
      isr_level = 3'd6;
      set_prio(0, 3'd2);
      enter_idle(1'b0, "R8 lower entry");
      irq_req = 4'b0001;
      expect_wake("R8 lower priority resumes", 1'b0, 0);
      in_service = 1'b0; isr_level = '0;
   endtask

   task automatic t_src_reset(input bit use_poc);
      enter_idle(1'b0, "R10 entry");
      if (use_poc) poc_rst = 1'b1; else lvd_rst = 1'b1;
      cyc(1);
      poc_rst = 1'b0; lvd_rst = 1'b0;
      chk("R10 reset source leaves idle", {31'd0, idle_state}, 0);
      chk("R10 cpu enabled", {31'd0, cpu_clk_en}, 1);
      chk("R10 no wake pulse", {31'd0, wake_pulse}, 0);
      wr(2'd1, 8'h01);
      cyc(5);
      chk("R10 mode back to default", {31'd0, idle_state}, 0);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_mode_ignore();
      t_basic_wake();
      t_mask();
      t_gdis_nmi();
      t_priority();
      t_resume();
      t_src_reset(1'b0);
      t_src_reset(1'b1);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule